// File: doc/BRIEF.md
# Serial Burst Memory Access Engine with Bit-Serial CRC-32

This block lets a debug host read and write blocks of memory through a JTAG data register. The host first shifts in a 53-bit command and pulses update. That command picks the direction and the word size, and gives the start address and the word count. The host then runs a second data scan, and a second update returns the engine to idle. The bus master port runs on the same TCK clock as the serial side.

In a write burst, the engine waits for a start bit. It then collects the data bytes, checks a reflected CRC-32 computed one bit at a time, and issues one bus write for each word. After the CRC it presents a single bit that reports whether the CRC matched. In a read burst, the engine fetches words ahead of the serial stream. It shifts out zeros until the first word is held, then a single 1 marker, then the data, then its own CRC-32. A bus error latches a flag and the failing address, which stay until they are cleared.

Top module: `jburst_engine`

## Requirements
- R1: While idle, each shift cycle moves TDI into a 53-bit command register, least significant bit first. The command is laid out from MSB to LSB as a 0 bit, a 4-bit opcode, a 32-bit start address and a 16-bit word count. An update in idle with a valid command starts a burst. An update in any other state returns the engine to idle.
- R2: In a write burst, TDI zeros shifted before the first 1 have no effect: no data is taken and no bus access is made.
- R3: Write opcodes 0x1, 0x2 and 0x3 carry 8-, 16- and 32-bit words, sent LSB first, with bytes in little-endian order. Each complete word becomes one bus write with bus_size 0, 1 or 2 and right-justified data. The request is held until it is acknowledged. The address then advances by the word size in bytes.
- R4: After the 32 CRC bits of a write burst, the next TDO bit is 1 when the received CRC equals the computed CRC, and 0 when it does not.
- R5: In a read burst (opcodes 0x5, 0x6, 0x7), TDO is 0 on every shift until the first word is held. Exactly one 1 status bit follows.
- R6: After the status bit, a read burst shifts out every word LSB first, in little-endian byte order, and then its CRC-32 LSB first.
- R7: The CRC starts at 0xFFFFFFFF and takes each data bit LSB first. On each bit it shifts right and XORs in 0xEDB88320 when the data bit differs from the old CRC bit 0. No final inversion is applied, so an empty burst carries 0xFFFFFFFF.
- R8: A burst with a word count of 0 makes no bus access.
- R9: An acknowledged access with bus_err set raises err_flag and captures that access's address in err_addr. An err_clr pulse clears err_flag.
- R10: A read burst requests its first word in the cycle after the update. It keeps one word fetched ahead, so the stream does not pause after the status bit.
- R11: After reset, TDO is 0, no bus request is active and err_flag is 0.
- R12: A command with its MSB set, or with an opcode outside the six listed, starts nothing. No bus access follows, and TDO stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TCK, also the bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Data register shift strobe |
| update_en | input | 1 | Data register update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Byte address of the access |
| bus_size | output | 2 | 0 = 8 bit, 1 = 16 bit, 2 = 32 bit |
| bus_wdata | output | 32 | Right-justified write data |
| bus_rdata | input | 32 | Right-justified read data |
| bus_ack | input | 1 | Access completed this cycle |
| bus_err | input | 1 | Completed access failed |
| err_clr | input | 1 | Clears the error flag |
| err_flag | output | 1 | Sticky bus error flag |
| err_addr | output | 32 | Address of the last failed access |

## Verification
The assertions assume that the host never pulses update while a bus request is still waiting for its acknowledge. They also assume that the bus answers each access within fewer cycles than one word takes to shift. The stimulus meets both conditions. Its bus model acknowledges in the same cycle as the request, except when a read deliberately holds the bus off before the status bit. The host closes every data scan with an update only after the last bit has been shifted.

// File: rtl/jbe_pkg.sv
`timescale 1ns/1ps
package jbe_pkg;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int OP_W   = 4;
    localparam int HDR_W  = 1 + OP_W + ADDR_W + CNT_W;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WR_WAIT, ST_WR_DATA, ST_WR_CRC, ST_WR_MATCH,
        ST_RD_WAIT, ST_RD_DATA, ST_RD_CRC, ST_DONE
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [1:0]        sz;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic [CNT_W-1:0]  fetch_left;
        logic [BIT_W-1:0]  bitc;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] nxt;
        logic              cur_v;
        logic              nxt_v;
        logic              req;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [31:0]       rx;
        logic              match;
        logic              err;
        logic [ADDR_W-1:0] err_addr;
    } core_t;

    // low two opcode bits select size, bit 2 selects read, bit 3 must be 0
    function automatic logic op_valid(input logic [OP_W-1:0] op);
        return (op[3] == 1'b0) && (op[1:0] != 2'b00);
    endfunction
endpackage

// File: rtl/jbe_cmd.sv
`timescale 1ns/1ps
module jbe_cmd
    import jbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              tdi_i,
    output logic              ok_o,
    output logic              rd_o,
    output logic [1:0]        size_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  cnt_o
);
    logic [HDR_W-1:0] hdr_d, hdr_q;
    logic [OP_W-1:0]  op;

    always_comb begin
        hdr_d = hdr_q;
        if (shift_i) hdr_d = {tdi_i, hdr_q[HDR_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hdr_q <= '0;
        else        hdr_q <= hdr_d;
    end

    assign op     = hdr_q[HDR_W-2 -: OP_W];
    assign ok_o   = !hdr_q[HDR_W-1] && op_valid(op);
    assign rd_o   = op[2];
    assign size_o = op[1:0] - 2'd1;
    assign addr_o = hdr_q[CNT_W +: ADDR_W];
    assign cnt_o  = hdr_q[CNT_W-1:0];
endmodule

// File: rtl/jbe_crc.sv
`timescale 1ns/1ps
module jbe_crc
    import jbe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        step_i,
    input  logic        bit_i,
    input  logic        shout_i,
    output logic [31:0] crc_o
);
    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init_i)       crc_d = '1;
        else if (step_i)  crc_d = (crc_q >> 1) ^ ((crc_q[0] ^ bit_i) ? CRC_POLY : 32'h0);
        else if (shout_i) crc_d = crc_q >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/jbe_core.sv
`timescale 1ns/1ps
module jbe_core
    import jbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              update_i,
    input  logic              tdi_i,
    input  logic              cmd_ok_i,
    input  logic              cmd_rd_i,
    input  logic [1:0]        cmd_size_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [CNT_W-1:0]  cmd_cnt_i,
    input  logic [31:0]       crc_i,
    output logic              crc_init_o,
    output logic              crc_step_o,
    output logic              crc_bit_o,
    output logic              crc_shout_o,
    output logic              tdo_o,
    output logic              idle_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [1:0]        bus_size_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    input  logic              err_clr_i,
    output logic              err_flag_o,
    output logic [ADDR_W-1:0] err_addr_o
);
    core_t q, n;
    logic [BIT_W:0]    nb;
    logic              last, got;
    logic [ADDR_W-1:0] step;

    always_comb begin
        n           = q;
        crc_init_o  = 1'b0;
        crc_step_o  = 1'b0;
        crc_bit_o   = tdi_i;
        crc_shout_o = 1'b0;
        tdo_o       = 1'b0;
        nb          = (BIT_W+1)'(8) << q.sz;
        last        = (q.bitc == BIT_W'(nb - 1'b1));
        step        = ADDR_W'(1) << q.sz;
        got         = 1'b0;

        // bus completion first, so a new request below may follow at once
        if (err_clr_i) n.err = 1'b0;
        if (q.req && bus_ack_i) begin
            n.req  = 1'b0;
            n.addr = q.addr + step;
            got    = !q.we;
            if (bus_err_i) begin
                n.err      = 1'b1;
                n.err_addr = q.addr;
            end
        end

        case (q.st)
            ST_WR_WAIT: if (shift_i && tdi_i) begin
                n.st   = (q.left == '0) ? ST_WR_CRC : ST_WR_DATA;
                n.bitc = '0;
            end
            ST_WR_DATA: if (shift_i) begin
                crc_step_o = 1'b1;
                n.sh   = {tdi_i, q.sh[DATA_W-1:1]};
                n.bitc = q.bitc + 1'b1;
                if (last) begin
                    n.bitc  = '0;
                    n.req   = 1'b1;
                    n.we    = 1'b1;
                    n.wdata = n.sh >> ((BIT_W+1)'(DATA_W) - nb);
                    n.left  = q.left - 1'b1;
                    if (q.left == CNT_W'(1)) n.st = ST_WR_CRC;
                end
            end
            ST_WR_CRC: if (shift_i) begin
                n.rx   = {tdi_i, q.rx[31:1]};
                n.bitc = q.bitc + 1'b1;
                if (q.bitc == '1) begin
                    n.match = (n.rx == crc_i);
                    n.st    = ST_WR_MATCH;
                end
            end
            ST_WR_MATCH: begin
                tdo_o = q.match;
                if (shift_i) n.st = ST_DONE;
            end
            ST_RD_WAIT: begin
                tdo_o = q.cur_v || (q.left == '0);
                if (shift_i && tdo_o) begin
                    n.st   = (q.left == '0) ? ST_RD_CRC : ST_RD_DATA;
                    n.bitc = '0;
                end
            end
            ST_RD_DATA: begin
                tdo_o     = q.sh[0];
                crc_bit_o = q.sh[0];
                if (shift_i) begin
                    crc_step_o = 1'b1;
                    n.sh   = q.sh >> 1;
                    n.bitc = q.bitc + 1'b1;
                    if (last) begin
                        n.bitc  = '0;
                        n.left  = q.left - 1'b1;
                        n.sh    = q.nxt;
                        n.cur_v = q.nxt_v;
                        n.nxt_v = 1'b0;
                        if (q.left == CNT_W'(1)) n.st = ST_RD_CRC;
                    end
                end
            end
            ST_RD_CRC: begin
                tdo_o = crc_i[0];
                if (shift_i) begin
                    crc_shout_o = 1'b1;
                    n.bitc = q.bitc + 1'b1;
                    if (q.bitc == '1) n.st = ST_DONE;
                end
            end
            default: ;
        endcase

        // returned read word lands in the stream slot or the spare slot
        if (got) begin
            n.fetch_left = n.fetch_left - 1'b1;
            if (!n.cur_v) begin
                n.sh    = bus_rdata_i;
                n.cur_v = 1'b1;
            end else begin
                n.nxt   = bus_rdata_i;
                n.nxt_v = 1'b1;
            end
        end
        if ((q.st == ST_RD_WAIT || q.st == ST_RD_DATA) && !n.req &&
            (n.fetch_left != '0) && !n.nxt_v) begin
            n.req = 1'b1;
            n.we  = 1'b0;
        end

        if (update_i) begin
            n.req = 1'b0;
            n.st  = ST_IDLE;
            if (q.st == ST_IDLE && cmd_ok_i) begin
                crc_init_o   = 1'b1;
                n.st         = cmd_rd_i ? ST_RD_WAIT : ST_WR_WAIT;
                n.sz         = cmd_size_i;
                n.addr       = cmd_addr_i;
                n.left       = cmd_cnt_i;
                n.fetch_left = cmd_rd_i ? cmd_cnt_i : '0;
                n.req        = cmd_rd_i && (cmd_cnt_i != '0);
                n.we         = 1'b0;
                n.cur_v      = 1'b0;
                n.nxt_v      = 1'b0;
                n.bitc       = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign idle_o      = (q.st == ST_IDLE);
    assign bus_req_o   = q.req;
    assign bus_we_o    = q.we;
    assign bus_addr_o  = q.addr;
    assign bus_size_o  = q.sz;
    assign bus_wdata_o = q.wdata;
    assign err_flag_o  = q.err;
    assign err_addr_o  = q.err_addr;
endmodule

// File: rtl/jburst_engine.sv
`timescale 1ns/1ps
module jburst_engine
    import jbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              tdi,
    output logic              tdo,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic              err_clr,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    logic              core_idle, cmd_ok, cmd_rd;
    logic [1:0]        cmd_size;
    logic [ADDR_W-1:0] cmd_addr;
    logic [CNT_W-1:0]  cmd_cnt;
    logic [31:0]       crc_val;
    logic              crc_init, crc_step, crc_bit, crc_shout;

    jbe_cmd cmd_i (
        .clk(clk), .rst_n(rst_n), .shift_i(shift_en && core_idle), .tdi_i(tdi),
        .ok_o(cmd_ok), .rd_o(cmd_rd), .size_o(cmd_size), .addr_o(cmd_addr), .cnt_o(cmd_cnt)
    );

    jbe_crc crc_i (
        .clk(clk), .rst_n(rst_n), .init_i(crc_init), .step_i(crc_step),
        .bit_i(crc_bit), .shout_i(crc_shout), .crc_o(crc_val)
    );

    jbe_core core_i (
        .clk(clk), .rst_n(rst_n), .shift_i(shift_en), .update_i(update_en), .tdi_i(tdi),
        .cmd_ok_i(cmd_ok), .cmd_rd_i(cmd_rd), .cmd_size_i(cmd_size),
        .cmd_addr_i(cmd_addr), .cmd_cnt_i(cmd_cnt), .crc_i(crc_val),
        .crc_init_o(crc_init), .crc_step_o(crc_step), .crc_bit_o(crc_bit),
        .crc_shout_o(crc_shout), .tdo_o(tdo), .idle_o(core_idle),
        .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
        .bus_size_o(bus_size), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
        .bus_ack_i(bus_ack), .bus_err_i(bus_err), .err_clr_i(err_clr),
        .err_flag_o(err_flag), .err_addr_o(err_addr)
    );
endmodule

// File: rtl/jbe_checker.sv
`timescale 1ns/1ps
module jbe_checker
    import jbe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              update_en,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_err,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              err_clr,
    input logic              err_flag,
    input logic [ADDR_W-1:0] err_addr,
    input logic              idle,
    input logic              cmd_ok,
    input logic              cmd_rd,
    input logic [CNT_W-1:0]  cmd_cnt
);
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !update_en |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    a_r9_err_capture: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_err |=> err_flag && (err_addr == $past(bus_addr)));

    a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !(bus_req && bus_ack && bus_err) |=> !err_flag);

    a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        update_en && cmd_ok && (cmd_cnt == '0) |=> !bus_req);

    a_r12_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        update_en && !cmd_ok |=> !bus_req);

    a_r10_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
        update_en && idle && cmd_ok && cmd_rd && (cmd_cnt != '0) |=> bus_req && !bus_we);
endmodule

bind jburst_engine jbe_checker chk_i (
    .clk(clk), .rst_n(rst_n), .update_en(update_en), .bus_req(bus_req),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_we(bus_we), .bus_addr(bus_addr),
    .err_clr(err_clr), .err_flag(err_flag), .err_addr(err_addr), .idle(core_idle),
    .cmd_ok(cmd_ok), .cmd_rd(cmd_rd), .cmd_cnt(cmd_cnt)
);

// File: tb/jburst_engine_tb_top.sv
`timescale 1ns/1ps
module jburst_engine_tb_top;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0, err_clr = 1'b0;
    logic        tdo, bus_req, bus_we, bus_ack, bus_err, err_flag;
    logic [31:0] bus_addr, bus_wdata, bus_rdata, err_addr;
    logic [1:0]  bus_size;
    logic        stall = 1'b0, err_en = 1'b0;
    logic [7:0]  err_at = 8'h00;
    logic [7:0]  mem [256];
    logic [7:0]  bb [64];
    logic [7:0]  rb [64];
    logic [7:0]  a;
    int          checks = 0, errors = 0, nacc = 0;
    bit          done = 1'b0;

    typedef struct packed {
        logic [3:0]  op;
        logic [7:0]  addr;
        logic [15:0] cnt;
        logic [7:0]  seed;
    } vec_t;
    localparam vec_t VECS [6] = '{
        '{4'h1, 8'h00, 16'd5, 8'h11}, '{4'h2, 8'h10, 16'd3, 8'h5A},
        '{4'h3, 8'h20, 16'd4, 8'hC3}, '{4'h5, 8'h30, 16'd6, 8'h27},
        '{4'h6, 8'h40, 16'd3, 8'h9E}, '{4'h7, 8'h50, 16'd4, 8'h3D}};

    always #2.5 clk = ~clk;

    jburst_engine dut_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .update_en(update_en), .tdi(tdi),
        .tdo(tdo), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .err_clr(err_clr),
        .err_flag(err_flag), .err_addr(err_addr));

    assign a         = bus_addr[7:0];
    assign bus_ack   = bus_req && !stall;
    assign bus_err   = err_en && (a == err_at);
    assign bus_rdata = {mem[8'(a + 8'd3)], mem[8'(a + 8'd2)], mem[8'(a + 8'd1)], mem[a]};

    always @(posedge clk) if (bus_req && bus_ack) begin
        nacc <= nacc + 1;
        if (bus_we) begin
            mem[a] <= bus_wdata[7:0];
            if (bus_size != 2'd0) mem[8'(a + 8'd1)] <= bus_wdata[15:8];
            if (bus_size == 2'd2) begin
                mem[8'(a + 8'd2)] <= bus_wdata[23:16];
                mem[8'(a + 8'd3)] <= bus_wdata[31:24];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_bytes(input int nbytes);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < nbytes; i++)
            for (int k = 0; k < 8; k++)
                c = (c >> 1) ^ ((c[0] ^ bb[i][k]) ? 32'hEDB88320 : 32'h0);
        return c;
    endfunction

    task automatic sbit(input logic b, output logic o);
        @(negedge clk);
        tdi = b; shift_en = 1'b1;
        #1 o = tdo;
    endtask

    task automatic do_update();
        @(negedge clk);
        shift_en = 1'b0; update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0;
    endtask

    task automatic send_cmd(input logic msb, input logic [3:0] op, input logic [31:0] ad,
                            input logic [15:0] cnt);
        logic [52:0] h = {msb, op, ad, cnt};
        logic o;
        for (int i = 0; i < 53; i++) sbit(h[i], o);
        do_update();
    endtask

    function automatic int nbytes_of(input logic [3:0] op, input logic [15:0] cnt);
        return int'(cnt) * (1 << (int'(op[1:0]) - 1));
    endfunction

    task automatic wr_burst(input logic [3:0] op, input logic [7:0] ad, input logic [15:0] cnt,
                            input int lead, input bit corrupt, output logic m);
        int nb = nbytes_of(op, cnt);
        logic [31:0] c = crc_bytes(nb);
        logic o;
        if (corrupt) c = c ^ 32'h0001_0000;
        send_cmd(1'b0, op, {24'h0, ad}, cnt);
        for (int i = 0; i < lead; i++) sbit(1'b0, o);
        sbit(1'b1, o);
        for (int i = 0; i < nb; i++)
            for (int k = 0; k < 8; k++) sbit(bb[i][k], o);
        for (int k = 0; k < 32; k++) sbit(c[k], o);
        sbit(1'b0, m);
        do_update();
    endtask

    task automatic rd_burst(input logic [3:0] op, input logic [7:0] ad, input logic [15:0] cnt,
                            input int rel, output int zeros, output logic pre,
                            output logic [31:0] crc_got);
        int nb = nbytes_of(op, cnt);
        logic o = 1'b0;
        send_cmd(1'b0, op, {24'h0, ad}, cnt);
        pre = bus_req;
        zeros = 0;
        while (!o && zeros < 40) begin
            sbit(1'b0, o);
            if (!o) zeros++;
            if (zeros == rel) stall = 1'b0;
        end
        for (int i = 0; i < nb; i++)
            for (int k = 0; k < 8; k++) begin
                sbit(1'b0, o);
                rb[i][k] = o;
            end
        for (int k = 0; k < 32; k++) begin
            sbit(1'b0, o);
            crc_got[k] = o;
        end
        do_update();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic m, pre, o;
        logic [31:0] cg;
        int zeros, nb, snap;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 tdo after reset", {31'h0, tdo}, 32'h0);
        check("R11 bus_req after reset", {31'h0, bus_req}, 32'h0);
        check("R11 err_flag after reset", {31'h0, err_flag}, 32'h0);

        foreach (VECS[v]) begin
            nb = nbytes_of(VECS[v].op, VECS[v].cnt);
            if (!VECS[v].op[2]) begin
                for (int j = 0; j < nb; j++) bb[j] = 8'(VECS[v].seed + 8'(j * 37));
                wr_burst(VECS[v].op, VECS[v].addr, VECS[v].cnt, 0, 1'b0, m);
                check("R4 match bit", {31'h0, m}, 32'h1);
                for (int j = 0; j < nb; j++)
                    check("R1 R3 written byte", {24'h0, mem[8'(VECS[v].addr + 8'(j))]}, {24'h0, bb[j]});
            end else begin
                for (int j = 0; j < nb; j++) begin
                    bb[j] = VECS[v].seed ^ 8'(j * 11);
                    mem[8'(VECS[v].addr + 8'(j))] = bb[j];
                end
                rd_burst(VECS[v].op, VECS[v].addr, VECS[v].cnt, -1, zeros, pre, cg);
                check("R10 early fetch", {31'h0, pre}, 32'h1);
                check("R5 zeros before status", zeros, 0);
                for (int j = 0; j < nb; j++) check("R6 read byte", {24'h0, rb[j]}, {24'h0, bb[j]});
                check("R7 read crc", cg, crc_bytes(nb));
            end
        end

        // R2: leading zeros before the start bit
        for (int j = 0; j < 8; j++) bb[j] = 8'(8'hA0 + 8'(j));
        wr_burst(4'h3, 8'h80, 16'd2, 7, 1'b0, m);
        check("R2 match after lead zeros", {31'h0, m}, 32'h1);
        check("R2 first word byte", {24'h0, mem[8'h80]}, 32'hA0);
        check("R2 last word byte", {24'h0, mem[8'h87]}, 32'hA7);

        // R4: corrupted CRC
        for (int j = 0; j < 3; j++) bb[j] = 8'(8'h33 * j);
        wr_burst(4'h1, 8'h90, 16'd3, 0, 1'b1, m);
        check("R4 mismatch bit", {31'h0, m}, 32'h0);

        // R8 / R7: empty bursts
        snap = nacc;
        wr_burst(4'h2, 8'hC0, 16'd0, 0, 1'b0, m);
        check("R7 empty write crc matches", {31'h0, m}, 32'h1);
        rd_burst(4'h7, 8'hC0, 16'd0, -1, zeros, pre, cg);
        check("R7 empty read crc", cg, 32'hFFFFFFFF);
        check("R8 no request after empty read", {31'h0, pre}, 32'h0);
        check("R8 no bus access", nacc, snap);

        // R5: bus held off before the first word
        for (int j = 0; j < 8; j++) begin
            bb[j] = 8'(8'h5C + 8'(j * 3));
            mem[8'(8'h60 + 8'(j))] = bb[j];
        end
        stall = 1'b1;
        rd_burst(4'h7, 8'h60, 16'd2, 4, zeros, pre, cg);
        check("R5 zeros while held off", zeros, 4);
        check("R5 R6 data after hold", {rb[7], rb[6], rb[5], rb[4]}, {bb[7], bb[6], bb[5], bb[4]});
        check("R7 crc after hold", cg, crc_bytes(8));

        // R9: bus error capture and clear
        for (int j = 0; j < 12; j++) bb[j] = 8'(j);
        err_en = 1'b1; err_at = 8'hA4;
        wr_burst(4'h3, 8'hA0, 16'd3, 0, 1'b0, m);
        err_en = 1'b0;
        check("R9 error flag", {31'h0, err_flag}, 32'h1);
        check("R9 error address", err_addr, 32'h0000_00A4);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check("R9 flag cleared", {31'h0, err_flag}, 32'h0);

        // R12: invalid opcode and set MSB
        snap = nacc;
        send_cmd(1'b0, 4'h4, 32'h10, 16'd2);
        check("R12 no request on bad opcode", {31'h0, bus_req}, 32'h0);
        m = 1'b0;
        for (int i = 0; i < 6; i++) begin
            sbit(1'b1, o);
            m = m | o;
        end
        do_update();
        check("R12 tdo stays low", {31'h0, m}, 32'h0);
        send_cmd(1'b1, 4'h7, 32'h10, 16'd2);
        check("R12 no request with MSB set", {31'h0, bus_req}, 32'h0);
        repeat (4) @(negedge clk);
        check("R12 no bus access", nacc, snap);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule